// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block keeps the most recent taken target of conditional branches in a 4-way, 128-set store of 512 entries. A fetch stage presents a branch address on the lookup port and gets back, in the same cycle, whether the branch is known and which target it last jumped to. The buffer is coupled to an outcome predictor. A hit passes that predictor's direction through as the prediction. A miss falls back to a fixed rule on the sign of the branch displacement: backward branches are taken and forward branches are not.

Resolved branches come back on the update port. A taken branch refreshes its entry, or claims a way in its set if it has none. A not-taken branch leaves the store untouched. Within a set, ways are replaced in true least-recently-used order. Both lookups that hit and updates that write count as uses. Branches whose addresses differ by a multiple of 2048 bytes share a set, so a fifth such branch pushes out the stalest of the other four.

Both ports carry a valid strobe and no ready. The block takes one lookup and one update in every cycle, so it never applies back-pressure. A caller may hold a strobe high for as long as it has work.

Top module: `br_target_cache`

## Requirements
- R1: Four taken branches with distinct tags that share one set are all held at once, and each then hits with its own target.
- R2: The set is chosen by address bits [10:4] and the tag is bits [31:11]. Bits [3:0] take no part, so addresses that differ only there hit the same entry. An address 2048 bytes away (next tag, same set) misses.
- R3: A lookup is answered combinationally in the cycle it is presented. An update becomes visible to lookups from the cycle after its clock edge.
- R4: An update with `upd_taken`=1 writes `upd_target` into the branch's entry. It allocates a way on a miss and overwrites the target on a hit, so a lookup returns the last taken target.
- R5: An update with `upd_taken`=0 changes nothing. An absent branch still misses, and a present branch keeps its old target.
- R6: Allocation fills an empty way first. Otherwise it replaces the way in the set that has gone longest without a lookup hit or a write.
- R7: Reset empties every way, and every lookup then misses.
- R8: On a miss, `pred_dynamic`=0 and `pred_taken` equals `lk_disp_neg` (1 means a negative displacement, i.e. a backward branch).
- R9: On a hit, `pred_dynamic`=1 and `pred_taken` follows `dyn_taken`.
- R10: When a lookup and an update arrive in the same cycle, the lookup sees the contents from before the update. If both fall in one set, only the update's use counts toward replacement age.
- R11: Five taken branches that share one set, visited round-robin, evict one another, and every lookup in the second round misses.
- R12: With `lk_valid`=0 the outputs report a miss (`lk_hit`=0, `pred_dynamic`=0), and the presented address does not count as a use for replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | 32 | Address of the branch being looked up |
| lk_disp_neg | input | 1 | Displacement sign of the looked-up branch, 1 = backward |
| dyn_taken | input | 1 | Direction from the outcome predictor |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Target the resolved branch went to |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| lk_hit | output | 1 | Looked-up branch is present |
| lk_target | output | 32 | Stored target on a hit, zero otherwise |
| pred_dynamic | output | 1 | Prediction comes from the outcome predictor |
| pred_taken | output | 1 | Predicted direction |

## Verification
A lookup and an update can land in the same cycle, and both want to read the store and age the same set. The bench drives both strobes together in two cases. In the first, the lookup targets the very entry being rewritten, and it must return the old target in that cycle and the new one a cycle later. In the second, the lookup hits one way of a set while the update refreshes another way of it. The outcome is judged by the next allocation in that set: it must evict the way the lookup hit. That way would have been spared if the lookup had counted as a use.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int unsigned BT_ADDR_W  = 32;
  localparam int unsigned BT_TGT_W   = 32;
  localparam int unsigned BT_WAYS    = 4;
  localparam int unsigned BT_SETS    = 128;
  localparam int unsigned BT_SET_LSB = 4;
endpackage

// File: rtl/bt_way_match.sv
module bt_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 21,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]            row_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tags,
  input  logic [TAG_W-1:0]           probe_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = row_valid[w] && (row_tags[w] == probe_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
    end
  end
endmodule

// File: rtl/bt_entry_array.sv
module bt_entry_array #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 128,
  parameter int unsigned TAG_W = 21,
  parameter int unsigned TGT_W = 32,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SET_W-1:0]           rd0_set,
  output logic [WAYS-1:0]            rd0_valid,
  output logic [WAYS-1:0][TAG_W-1:0] rd0_tags,
  output logic [WAYS-1:0][TGT_W-1:0] rd0_tgts,
  input  logic [SET_W-1:0]           rd1_set,
  output logic [WAYS-1:0]            rd1_valid,
  output logic [WAYS-1:0][TAG_W-1:0] rd1_tags,
  input  logic                       wr_en,
  input  logic [SET_W-1:0]           wr_set,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic [TGT_W-1:0]           wr_tgt
);
  logic [SETS-1:0][WAYS-1:0]  valid_q;
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][TGT_W-1:0] tgt_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wr_way] <= wr_tag;
      tgt_q[wr_set][wr_way] <= wr_tgt;
    end
  end

  assign rd0_valid = valid_q[rd0_set];
  assign rd0_tags  = tag_q[rd0_set];
  assign rd0_tgts  = tgt_q[rd0_set];
  assign rd1_valid = valid_q[rd1_set];
  assign rd1_tags  = tag_q[rd1_set];

  // R7: a reset cycle leaves every way empty
  assert_reset_clear_R7: assert property (@(posedge clk) rst |=> (valid_q == '0));

  // R5: with no write request the occupancy map does not move
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/bt_lru_ctrl.sv
module bt_lru_ctrl #(
  parameter int unsigned WAYS = 4,
  parameter int unsigned SETS = 128,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_touch,
  input  logic [SET_W-1:0] lk_set,
  input  logic [WAY_W-1:0] lk_way,
  input  logic             up_touch,
  input  logic [SET_W-1:0] up_set,
  input  logic [WAY_W-1:0] up_way,
  output logic [WAY_W-1:0] up_oldest
);
  typedef logic [WAYS-1:0][WAY_W-1:0] age_row_t;

  age_row_t age_q [SETS];

  function automatic age_row_t touch_row(age_row_t cur, logic [WAY_W-1:0] way);
    age_row_t nxt;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == way)        nxt[w] = '0;
      else if (cur[w] < cur[way])  nxt[w] = cur[w] + 1'b1;
      else                         nxt[w] = cur[w];
    end
    return nxt;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      if (lk_touch && !(up_touch && up_set == lk_set))
        age_q[lk_set] <= touch_row(age_q[lk_set], lk_way);
      if (up_touch)
        age_q[up_set] <= touch_row(age_q[up_set], up_way);
    end
  end

  always_comb begin
    up_oldest = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[up_set][w] == WAY_W'(WAYS - 1)) up_oldest = WAY_W'(w);
    end
  end

  // R6: a touched way becomes the most recent in its set
  assert_touch_mru_R6: assert property (@(posedge clk) disable iff (rst)
    up_touch |=> (age_q[$past(up_set)][$past(up_way)] == '0));

  // R10: the caller must drop a lookup touch that collides with an update touch
  assert_lookup_yield_R10: assert property (@(posedge clk) disable iff (rst)
    (up_touch && lk_touch) |-> (up_set != lk_set));
endmodule

// File: rtl/br_target_cache.sv
module br_target_cache
  import bt_pkg::*;
#(
  parameter int unsigned ADDR_W  = BT_ADDR_W,
  parameter int unsigned TGT_W   = BT_TGT_W,
  parameter int unsigned WAYS    = BT_WAYS,
  parameter int unsigned SETS    = BT_SETS,
  parameter int unsigned SET_LSB = BT_SET_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_disp_neg,
  input  logic              dyn_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [TGT_W-1:0]  upd_target,
  input  logic              upd_taken,
  output logic              lk_hit,
  output logic [TGT_W-1:0]  lk_target,
  output logic              pred_dynamic,
  output logic              pred_taken
);
  localparam int unsigned WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned SET_W   = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned TAG_LSB = SET_LSB + SET_W;
  localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             unused_offset;

  assign lk_set = lk_addr[TAG_LSB-1:SET_LSB];
  assign lk_tag = lk_addr[ADDR_W-1:TAG_LSB];
  assign up_set = upd_addr[TAG_LSB-1:SET_LSB];
  assign up_tag = upd_addr[ADDR_W-1:TAG_LSB];
  assign unused_offset = ^{lk_addr[SET_LSB-1:0], upd_addr[SET_LSB-1:0]};

  logic [WAYS-1:0]            lk_row_valid, up_row_valid;
  logic [WAYS-1:0][TAG_W-1:0] lk_row_tags, up_row_tags;
  logic [WAYS-1:0][TGT_W-1:0] lk_row_tgts;
  logic                       wr_en;
  logic [WAY_W-1:0]           wr_way;

  bt_entry_array #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .rd0_set   (lk_set),
    .rd0_valid (lk_row_valid),
    .rd0_tags  (lk_row_tags),
    .rd0_tgts  (lk_row_tgts),
    .rd1_set   (up_set),
    .rd1_valid (up_row_valid),
    .rd1_tags  (up_row_tags),
    .wr_en     (wr_en),
    .wr_set    (up_set),
    .wr_way    (wr_way),
    .wr_tag    (up_tag),
    .wr_tgt    (upd_target)
  );

  logic [WAYS-1:0]  lk_vec, up_vec;
  logic             lk_match, up_match;
  logic [WAY_W-1:0] lk_way, up_way;

  bt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .row_valid (lk_row_valid),
    .row_tags  (lk_row_tags),
    .probe_tag (lk_tag),
    .hit_vec   (lk_vec),
    .hit       (lk_match),
    .hit_way   (lk_way)
  );

  bt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .row_valid (up_row_valid),
    .row_tags  (up_row_tags),
    .probe_tag (up_tag),
    .hit_vec   (up_vec),
    .hit       (up_match),
    .hit_way   (up_way)
  );

  // victim: lowest empty way, else least recently used
  logic [WAY_W-1:0] lru_way, victim;
  logic             empty_found;

  always_comb begin
    victim      = lru_way;
    empty_found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!empty_found && !up_row_valid[w]) begin
        victim      = WAY_W'(w);
        empty_found = 1'b1;
      end
    end
  end

  assign wr_en  = upd_valid && upd_taken;
  assign wr_way = up_match ? up_way : victim;

  logic lk_touch;
  assign lk_touch = lk_hit && !(wr_en && (up_set == lk_set));

  bt_lru_ctrl #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .lk_touch  (lk_touch),
    .lk_set    (lk_set),
    .lk_way    (lk_way),
    .up_touch  (wr_en),
    .up_set    (up_set),
    .up_way    (wr_way),
    .up_oldest (lru_way)
  );

  assign lk_hit       = lk_valid && lk_match;
  assign lk_target    = lk_hit ? lk_row_tgts[lk_way] : '0;
  assign pred_dynamic = lk_hit;
  assign pred_taken   = lk_hit ? dyn_taken : lk_disp_neg;

  // R1: a set never holds the same tag in two ways
  assert_single_hit_R1: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> $onehot0(lk_vec));

  // R4: a taken update is found with its target by a lookup one cycle later
  assert_write_visible_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && $past(upd_valid && upd_taken) &&
     (lk_addr[ADDR_W-1:SET_LSB] == $past(upd_addr[ADDR_W-1:SET_LSB])))
    |-> (lk_hit && (lk_target == $past(upd_target))));
endmodule

// File: tb/test_br_target_cache.sv
module test_br_target_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_disp_neg = 1'b0, dyn_taken = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;
  logic [31:0] upd_addr = '0, upd_target = '0;
  logic        lk_hit, pred_dynamic, pred_taken;
  logic [31:0] lk_target;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic        g_hit, g_dyn, g_tk;
  logic [31:0] g_tgt;

  always #5 clk = ~clk;

  br_target_cache i_br_target_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_disp_neg(lk_disp_neg), .dyn_taken(dyn_taken), .upd_valid(upd_valid),
    .upd_addr(upd_addr), .upd_target(upd_target), .upd_taken(upd_taken),
    .lk_hit(lk_hit), .lk_target(lk_target), .pred_dynamic(pred_dynamic),
    .pred_taken(pred_taken)
  );

  function automatic logic [31:0] mk(input logic [20:0] tag, input logic [6:0] set,
                                     input logic [3:0] off);
    return {tag, set, off};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic neg, input logic dyn);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_disp_neg = neg; dyn_taken = dyn;
    #1;
    g_hit = lk_hit; g_tgt = lk_target; g_dyn = pred_dynamic; g_tk = pred_taken;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic update(input logic [31:0] a, input logic [31:0] t, input logic tk);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_target = t; upd_taken = tk;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic expect_hit(input logic [31:0] a, input logic [31:0] t, input string req);
    lookup(a, 1'b0, 1'b1);
    chk(g_hit === 1'b1, req, "hit", 32'(g_hit), 32'd1);
    chk(g_tgt === t, req, "target", g_tgt, t);
  endtask

  task automatic expect_miss(input logic [31:0] a, input string req);
    lookup(a, 1'b0, 1'b1);
    chk(g_hit === 1'b0, req, "miss", 32'(g_hit), 32'd0);
  endtask

  task automatic fill4(input logic [6:0] s);
    for (int i = 0; i < 4; i++) update(mk(21'(100 + i), s, 4'h0), 32'(32'h1000 * s + i), 1'b1);
  endtask

  task automatic t_reset_state();
    expect_miss(mk(21'd1, 7'd1, 4'h0), "R7");
    expect_miss(mk(21'd0, 7'd0, 4'h0), "R7");
    chk(pred_dynamic === 1'b0, "R7", "dynamic idle", 32'(pred_dynamic), 32'd0);
  endtask

  task automatic t_static();
    lookup(mk(21'd3, 7'd2, 4'h0), 1'b1, 1'b0);
    chk(g_tk === 1'b1, "R8", "backward taken", 32'(g_tk), 32'd1);
    chk(g_dyn === 1'b0, "R8", "static source", 32'(g_dyn), 32'd0);
    lookup(mk(21'd3, 7'd2, 4'h0), 1'b0, 1'b1);
    chk(g_tk === 1'b0, "R8", "forward not taken", 32'(g_tk), 32'd0);
  endtask

  task automatic t_alloc();
    logic [31:0] a;
    a = mk(21'd7, 7'd5, 4'h0);
    update(a, 32'hAAAA_0001, 1'b1);
    lookup(a, 1'b1, 1'b0);
    chk(g_hit === 1'b1 && g_tgt === 32'hAAAA_0001, "R3", "hit after update", g_tgt, 32'hAAAA_0001);
    chk(g_dyn === 1'b1 && g_tk === 1'b0, "R9", "dyn not taken", {g_dyn, g_tk}, 32'd2);
    lookup(a, 1'b0, 1'b1);
    chk(g_tk === 1'b1, "R9", "dyn taken", 32'(g_tk), 32'd1);
    update(a, 32'hAAAA_0002, 1'b1);
    expect_hit(a, 32'hAAAA_0002, "R4");
  endtask

  task automatic t_index();
    update(mk(21'd5, 7'd9, 4'h0), 32'hBEEF_0009, 1'b1);
    expect_hit(mk(21'd5, 7'd9, 4'h8), 32'hBEEF_0009, "R2");
    expect_miss(mk(21'd5, 7'd10, 4'h0), "R2");
    expect_miss(mk(21'd6, 7'd9, 4'h0), "R2");
  endtask

  task automatic t_not_taken();
    update(mk(21'd11, 7'd12, 4'h0), 32'h1111_0000, 1'b0);
    expect_miss(mk(21'd11, 7'd12, 4'h0), "R5");
    update(mk(21'd12, 7'd12, 4'h0), 32'h2222_0000, 1'b1);
    update(mk(21'd12, 7'd12, 4'h0), 32'h3333_0000, 1'b0);
    expect_hit(mk(21'd12, 7'd12, 4'h0), 32'h2222_0000, "R5");
  endtask

  task automatic t_lru();
    logic [6:0] s;
    s = 7'd20;
    fill4(s);
    for (int i = 0; i < 4; i++) expect_hit(mk(21'(100 + i), s, 4'h0), 32'(32'h1000 * s + i), "R1");
    expect_hit(mk(21'd100, s, 4'h0), 32'(32'h1000 * s), "R6");
    update(mk(21'd200, s, 4'h0), 32'hE0E0_0020, 1'b1);
    expect_hit(mk(21'd100, s, 4'h0), 32'(32'h1000 * s), "R6");
    expect_miss(mk(21'd101, s, 4'h0), "R6");
    expect_hit(mk(21'd102, s, 4'h0), 32'(32'h1000 * s + 2), "R6");
    expect_hit(mk(21'd200, s, 4'h0), 32'hE0E0_0020, "R6");
  endtask

  task automatic t_same_cycle();
    logic [31:0] a;
    a = mk(21'd100, 7'd30, 4'h0);
    fill4(7'd30);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; upd_valid = 1'b1; upd_addr = a;
    upd_target = 32'h9999_0030; upd_taken = 1'b1;
    #1;
    chk(lk_hit === 1'b1 && lk_target === 32'(32'h1000 * 30), "R10", "old target same cycle",
        lk_target, 32'(32'h1000 * 30));
    @(negedge clk);
    upd_valid = 1'b0;
    #1;
    chk(lk_target === 32'h9999_0030, "R3", "new target next cycle", lk_target, 32'h9999_0030);
    @(negedge clk);
    lk_valid = 1'b0;
    fill4(7'd31);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(21'd100, 7'd31, 4'h0);
    upd_valid = 1'b1; upd_addr = mk(21'd102, 7'd31, 4'h0);
    upd_target = 32'h5555_0031; upd_taken = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    update(mk(21'd300, 7'd31, 4'h0), 32'h7777_0031, 1'b1);
    expect_miss(mk(21'd100, 7'd31, 4'h0), "R10");
    expect_hit(mk(21'd101, 7'd31, 4'h0), 32'(32'h1000 * 31 + 1), "R10");
  endtask

  task automatic t_idle_lookup();
    fill4(7'd40);
    @(negedge clk);
    lk_valid = 1'b0; lk_addr = mk(21'd100, 7'd40, 4'h0);
    #1;
    chk(lk_hit === 1'b0 && pred_dynamic === 1'b0, "R12", "idle reports miss",
        {lk_hit, pred_dynamic}, 32'd0);
    update(mk(21'd400, 7'd40, 4'h0), 32'h4040_0000, 1'b1);
    expect_miss(mk(21'd100, 7'd40, 4'h0), "R12");
  endtask

  task automatic t_thrash();
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 5; i++) begin
        lookup(mk(21'(500 + i), 7'd50, 4'h0), 1'b0, 1'b1);
        if (r == 1) chk(g_hit === 1'b0, "R11", "thrash miss", 32'(g_hit), 32'd0);
        update(mk(21'(500 + i), 7'd50, 4'h0), 32'(32'h5000 + i), 1'b1);
      end
    end
  endtask

  task automatic t_reset_again();
    do_reset();
    expect_miss(mk(21'd5, 7'd9, 4'h0), "R7");
    expect_miss(mk(21'd504, 7'd50, 4'h0), "R7");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_static();
    t_alloc();
    t_index();
    t_not_taken();
    t_lru();
    t_same_cycle();
    t_idle_lookup();
    t_thrash();
    t_reset_again();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule